// File: doc/BRIEF.md
# Central-Limit Gaussian Noise Source

This block is a fixed-point noise source that emits one pseudo-random sample on every enabled clock. A bank of independent uniform generators runs in parallel. Their outputs are summed, and the sum is divided by the number of generators. The average is then mapped onto a signed range of about [-1, +1) and shifted by a mean offset set at run time. The central limit theorem sets the shape of the result, and the generator count `NUM_SRC` picks it. One generator gives a flat distribution, two give a triangle, and a dozen or so give a close approximation of a Gaussian bell.

The block is used as a stimulus or dither source inside a signal-processing datapath. Holding `enable` low freezes the generators and the output together. `sampleValid` marks the cycles that carry a fresh sample. The output format is signed Q1.15.

Top module: `clt_noise_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sampleOut` becomes 0 and `sampleValid` becomes 0 after that edge.
- R2: `sampleValid` after a rising edge equals the value `enable` had at that edge (reset aside).
- R3: When `enable` is low at an edge, `sampleOut` keeps its previous value after that edge.
- R4: Generator k (k = 0..NUM_SRC-1) is a 24-bit register. Reset loads it with seed (0x5A5A5A + k*0x3C6EF3) mod 2^24, and a zero seed is replaced by 1. Each enabled edge shifts it left, and the new bit 0 is bit23 ^ bit22 ^ bit21 ^ bit16 of the old state. Its uniform value u_k is bits [23:8] of the state, read as an unsigned fraction of 65536.
- R5: The generators change state only on edges where `enable` is high. A paused sequence resumes exactly where it stopped.
- R6: On an enabled edge, `sampleOut` takes sat(round(S/NUM_SRC) - 32768 + meanOffset), within one LSB. Here S is the sum of the u_k values held before that edge, and `meanOffset` is signed Q1.15.
- R7: The result saturates to 32767 when the true value is above it and to -32768 when it is below. It never wraps.
- R8: With NUM_SRC = 1 the result is exactly sat(u_0 - 32768 + meanOffset), which is a flat distribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance generators and capture a new sample |
| meanOffset | input | 16 | Signed Q1.15 offset added to the centred sample |
| sampleOut | output | 16 | Signed Q1.15 noise sample |
| sampleValid | output | 1 | High for the cycle after an enabled edge |

## Verification
Each result is due one edge after its stimulus:
- the sample reflects the generator states held before the enabled edge;
- the valid flag mirrors `enable` at that same edge;
- the generators step on that edge.

The bench drives the inputs on the falling edge before a rising edge and reads the outputs on the following falling edge. It evaluates its own generator model before stepping it, so each expected value lines up with the exact edge that produced it. A pause in `enable` leaves the model untouched, which makes any step on a disabled edge show up as a sequence mismatch.

// File: rtl/clt_noise_pkg.sv
package clt_noise_pkg;

  localparam int LFSR_W = 24;

  typedef struct packed {
    logic advance;   // step every uniform generator
    logic capture;   // load the output register
  } noiseStrobe_t;

  function automatic logic [LFSR_W-1:0] seedFor(input int idx);
    logic [LFSR_W-1:0] s;
    s = 24'h5A5A5A + LFSR_W'(idx) * 24'h3C6EF3;
    if (s == '0) s = 24'd1;
    return s;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsrNext(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

endpackage

// File: rtl/clt_noise_ctrl.sv
module clt_noise_ctrl
  import clt_noise_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  output noiseStrobe_t strobe,
  output logic         validQ
);

  always_comb begin
    strobe.advance = enable;
    strobe.capture = enable;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= enable;
  end

endmodule

// File: rtl/clt_noise_dp.sv
module clt_noise_dp
  import clt_noise_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int SAMPLE_W = 16,
  parameter int RECIP_SH = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  noiseStrobe_t               strobe,
  input  logic signed [SAMPLE_W-1:0] meanOffset,
  output logic signed [SAMPLE_W-1:0] sampleQ
);

  localparam int SUM_W   = SAMPLE_W + $clog2(NUM_SRC + 1);
  localparam int RECIP_W = RECIP_SH + 1;
  localparam int PROD_W  = SUM_W + RECIP_W;
  localparam int CEN_W   = SUM_W + 2;
  localparam logic [RECIP_W-1:0] RECIP_C =
    RECIP_W'(((64'd1 << RECIP_SH) + 64'(NUM_SRC / 2)) / 64'(NUM_SRC));
  localparam logic [PROD_W-1:0] ROUND_C = PROD_W'(1) << (RECIP_SH - 1);
  localparam logic signed [CEN_W-1:0] MID_C = CEN_W'(2 ** (SAMPLE_W - 1));
  localparam logic signed [CEN_W-1:0] MAX_C = CEN_W'(2 ** (SAMPLE_W - 1) - 1);
  localparam logic signed [CEN_W-1:0] MIN_C = -MID_C;

  logic [SAMPLE_W-1:0] uniVal [NUM_SRC];

  // Independent uniform sources, one per summed term
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [LFSR_W-1:0] lfsrQ;
    always_ff @(posedge clk) begin
      if (rst)                 lfsrQ <= seedFor(g);
      else if (strobe.advance) lfsrQ <= lfsrNext(lfsrQ);
    end
    assign uniVal[g] = lfsrQ[LFSR_W-1 -: SAMPLE_W];
  end

  logic [SUM_W-1:0]         sumAcc;
  logic [PROD_W-1:0]        prodFull;
  logic [PROD_W-1:0]        prodRnd;
  logic [SUM_W-1:0]         quot;
  logic signed [CEN_W-1:0]  centred;
  logic signed [SAMPLE_W-1:0] satVal;

  always_comb begin
    sumAcc = '0;
    for (int i = 0; i < NUM_SRC; i++) sumAcc = sumAcc + SUM_W'(uniVal[i]);
  end

  // Divide by NUM_SRC through a reciprocal multiply with rounding
  always_comb begin
    prodFull = PROD_W'(sumAcc) * PROD_W'(RECIP_C);
    prodRnd  = prodFull + ROUND_C;
    quot     = prodRnd[RECIP_SH +: SUM_W];
    centred  = $signed({2'b00, quot}) - MID_C + CEN_W'(meanOffset);
    if (centred > MAX_C)      satVal = MAX_C[SAMPLE_W-1:0];
    else if (centred < MIN_C) satVal = MIN_C[SAMPLE_W-1:0];
    else                      satVal = centred[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                 sampleQ <= '0;
    else if (strobe.capture) sampleQ <= satVal;
  end

endmodule

// File: rtl/clt_noise_gen.sv
module clt_noise_gen
  import clt_noise_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic signed [15:0] meanOffset,
  output logic signed [15:0] sampleOut,
  output logic               sampleValid
);

  noiseStrobe_t strobe;

  clt_noise_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .strobe (strobe),
    .validQ (sampleValid)
  );

  clt_noise_dp #(
    .NUM_SRC  (NUM_SRC),
    .SAMPLE_W (16),
    .RECIP_SH (20)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .meanOffset (meanOffset),
    .sampleQ    (sampleOut)
  );

endmodule

// File: rtl/clt_noise_chk.sv
module clt_noise_chk (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic signed [15:0] meanOffset,
  input logic signed [15:0] sampleOut,
  input logic               sampleValid
);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (sampleOut == 16'sd0) && !sampleValid);

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    enable |=> sampleValid);

  p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sampleValid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(sampleOut));

  // R7: a positive offset can only push the sample up, never wrap it to the floor
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && meanOffset > 16'sd0) |=> (sampleOut != -16'sd32768));

endmodule

bind clt_noise_gen clt_noise_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .meanOffset  (meanOffset),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid)
);

// File: tb/clt_noise_gen_tb_top.sv
module clt_noise_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic signed [15:0] meanOffset = 16'sd0;
  logic signed [15:0] outMulti, outOne;
  logic validMulti, validOne;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [23:0] mdlMulti [4];
  logic [23:0] mdlOne;

  always #2.5 clk = ~clk;

  clt_noise_gen #(.NUM_SRC(4)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .meanOffset(meanOffset),
    .sampleOut(outMulti), .sampleValid(validMulti));

  clt_noise_gen #(.NUM_SRC(1)) dutOne_i (
    .clk(clk), .rst(rst), .enable(enable), .meanOffset(meanOffset),
    .sampleOut(outOne), .sampleValid(validOne));

  // Seed and step rule as given in R4
  function automatic logic [23:0] seedOf(input int k);
    logic [23:0] s;
    s = 24'h5A5A5A + 24'(k) * 24'h3C6EF3;
    if (s == 24'd0) s = 24'd1;
    return s;
  endfunction

  function automatic logic [23:0] stepOf(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic int satQ15(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic reseed();
    for (int k = 0; k < 4; k++) mdlMulti[k] = seedOf(k);
    mdlOne = seedOf(0);
  endtask

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 multi sample", int'(outMulti), 0, 0);
    check("R1 multi valid", int'(validMulti), 0, 0);
    check("R1 single sample", int'(outOne), 0, 0);
    check("R1 single valid", int'(validOne), 0, 0);
    rst = 1'b0;
    enable = 1'b0;
    reseed();
  endtask

  // Called at a falling edge; checks the result after the next rising edge
  task automatic doCycle(input logic en, input int m);
    int sumS, expMulti, expOne, prevMulti, prevOne;
    enable = en;
    meanOffset = 16'(m);
    prevMulti = int'(outMulti);
    prevOne = int'(outOne);
    sumS = 0;
    for (int k = 0; k < 4; k++) sumS += int'(mdlMulti[k][23:8]);
    expMulti = satQ15((2 * sumS + 4) / 8 - 32768 + m);
    expOne = satQ15(int'(mdlOne[23:8]) - 32768 + m);
    @(posedge clk);
    if (en) begin
      for (int k = 0; k < 4; k++) mdlMulti[k] = stepOf(mdlMulti[k]);
      mdlOne = stepOf(mdlOne);
    end
    @(negedge clk);
    check("R2 valid multi", int'(validMulti), int'(en), 0);
    check("R2 valid single", int'(validOne), int'(en), 0);
    if (en) begin
      check("R6 multi sample", int'(outMulti), expMulti, 1);
      check("R8 single sample", int'(outOne), expOne, 0);
    end else begin
      check("R3 multi hold", int'(outMulti), prevMulti, 0);
      check("R3 single hold", int'(outOne), prevOne, 0);
    end
  endtask

  initial begin
    reseed();
    @(posedge clk);
    @(negedge clk);
    check("R1 initial sample", int'(outMulti), 0, 0);
    check("R1 initial valid", int'(validMulti), 0, 0);
    rst = 1'b0;

    // R4/R6: free run at zero offset
    for (int i = 0; i < 3000; i++) doCycle(1'b1, 0);
    // R6: several offsets
    for (int i = 0; i < 500; i++) doCycle(1'b1, -16384);
    for (int i = 0; i < 500; i++) doCycle(1'b1, 8192);
    // R7: saturation at both ends
    for (int i = 0; i < 500; i++) doCycle(1'b1, 32767);
    for (int i = 0; i < 500; i++) doCycle(1'b1, -32768);
    for (int i = 0; i < 300; i++) doCycle(1'b1, 20000);
    // R3/R5: gated enable, sequence must resume without skips
    for (int i = 0; i < 2000; i++) doCycle((i % 3) != 1, (i * 37) % 4000 - 2000);
    for (int i = 0; i < 50; i++) doCycle(1'b0, 1000);
    for (int i = 0; i < 200; i++) doCycle(1'b1, 0);
    // R1/R4: reset mid-run restarts from the seeds
    applyReset();
    for (int i = 0; i < 1000; i++) doCycle(1'b1, 123);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule